// File: doc/BRIEF.md
# Erase Flag Table Tracker

This block watches the erase events issued by a flash garbage collector and decides when static wear leveling is due. The physical blocks are split into groups of 2^k neighbours, and one flag bit per group records whether any block of that group has been erased since the table was last cleared. Alongside the table the block keeps two counters. One counts every erase. The other counts the flags that are set.

The leveling request is raised when the erases per flagged group reach a programmable threshold T. This means a small set of hot groups is absorbing the erase traffic while the other groups sit idle. Once every group has been flagged, the table and both counters clear themselves and a new interval begins.

The firmware that performs the leveling reads the flag bits through a read port to pick out a group that has not been erased yet.

Top module: `erase_flag_tracker`

## Requirements
- R1: After reset, both counters are zero, every flag reads 0 and `level_req` is low.
- R2: An erase of block b sets flag index b >> k_eff, where k_eff is `grp_shift` clamped to BLK_W. The flag can be read on `rd_flag` (with `rd_idx` = that index) from the cycle after the event.
- R3: Each erase event adds one to `erase_cnt`. Repeated erases in the same group each count.
- R4: `flag_cnt` rises by one only when an erase finds its flag at 0. Otherwise it is unchanged, so it always equals the number of set flags.
- R5: `level_req` is high exactly when `flag_cnt` is non-zero and `erase_cnt >= thresh * flag_cnt`. For example, 100 erases with one flag set and T=100 raise it, while 101 erases with two flags set do not.
- R6: `level_req` is low whenever `flag_cnt` is zero, for any threshold including 0.
- R7: When `flag_cnt` equals the group count (2^BLK_W >> k_eff) and no erase arrives, the next cycle shows both counters at zero and all flags cleared.
- R8: An erase that arrives while the table is full is applied after the clear. The next cycle shows `erase_cnt` = 1, `flag_cnt` = 1, and only that group's flag set.
- R9: `erase_cnt` saturates at 2^CNT_W - 1 and does not wrap.
- R10: A cycle without `erase_vld` and without a full table leaves the counters and flags unchanged.
- R11: A `grp_shift` larger than BLK_W behaves as BLK_W, which gives a single group. In that case every erase fills the table.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| erase_vld | input | 1 | One-cycle strobe for one block erase |
| erase_blk | input | BLK_W | Index of the erased physical block |
| thresh | input | THR_W | Unevenness threshold T |
| grp_shift | input | SH_W | Group-size exponent k, held static between resets |
| rd_idx | input | BLK_W | Flag index to read |
| rd_flag | output | 1 | Flag at `rd_idx` |
| level_req | output | 1 | Static leveling requested |
| erase_cnt | output | CNT_W | Erases since the last table clear (saturating) |
| flag_cnt | output | BLK_W+1 | Number of set flags |

## Verification
The bench concentrates on the interval boundary. It covers a full table that clears on its own and an erase that lands in that very cycle. A design that records the erase before clearing would lose it and show zero counts. A design that ignores the clear would count past the group total.

Repeated erases of an already flagged group are aimed at `flag_cnt`. A version that increments on every erase would lower the ratio and hold back the trigger. The threshold is also tested at exact equality, at zero, and with an empty table, which would expose an off-by-one compare or a trigger on a zero divisor.

The bench drives the counter into saturation to catch wrap-around, and it uses an oversized exponent to check the single-group clamp.

// File: rtl/ewl_pkg.sv
package ewl_pkg;
  // Clamp a group-size exponent to the widest meaningful value.
  function automatic int unsigned clamp_shift(input int unsigned k, input int unsigned kmax);
    return (k > kmax) ? kmax : k;
  endfunction
endpackage

// File: rtl/ewl_flag_table.sv
module ewl_flag_table #(
  parameter int IDX_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic             clr_all,
  input  logic [IDX_W-1:0] rd_idx,
  output logic             rd_flag,
  output logic             set_fresh
);
  localparam int DEPTH = 1 << IDX_W;

  logic [DEPTH-1:0] flags_q;
  logic [DEPTH-1:0] flags_d;
  logic             flags_en;

  // Clear is applied first, then the new erase lands in the cleared table.
  always_comb begin
    flags_d = clr_all ? '0 : flags_q;
    if (set_en) flags_d[set_idx] = 1'b1;
  end

  assign flags_en  = set_en | clr_all;
  assign set_fresh = clr_all | ~flags_q[set_idx];
  assign rd_flag   = flags_q[rd_idx];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        flags_q <= '0;
    else if (flags_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/ewl_counters.sv
module ewl_counters #(
  parameter int CNT_W = 16,
  parameter int FC_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ev,
  input  logic             fresh,
  input  logic             clr,
  output logic [CNT_W-1:0] erase_cnt,
  output logic [FC_W-1:0]  flag_cnt
);
  localparam logic [CNT_W-1:0] E_MAX = '1;

  logic [CNT_W-1:0] e_q, e_d, e_base;
  logic [FC_W-1:0]  f_q, f_d, f_base;
  logic             cnt_en;

  always_comb begin
    e_base = clr ? '0 : e_q;
    f_base = clr ? '0 : f_q;
    e_d    = e_base;
    f_d    = f_base;
    if (ev) begin
      e_d = (e_base == E_MAX) ? E_MAX : e_base + 1'b1;
      if (fresh) f_d = f_base + 1'b1;
    end
  end

  assign cnt_en = ev | clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      e_q <= '0;
      f_q <= '0;
    end else if (cnt_en) begin
      e_q <= e_d;
      f_q <= f_d;
    end
  end

  assign erase_cnt = e_q;
  assign flag_cnt  = f_q;
endmodule

// File: rtl/ewl_ratio_cmp.sv
module ewl_ratio_cmp #(
  parameter int CNT_W = 16,
  parameter int THR_W = 12,
  parameter int FC_W  = 9
) (
  input  logic [CNT_W-1:0] erase_cnt,
  input  logic [FC_W-1:0]  flag_cnt,
  input  logic [THR_W-1:0] thresh,
  output logic             hit
);
  localparam int PW = THR_W + FC_W;
  localparam int CW = (PW > CNT_W) ? PW : CNT_W;

  logic [PW-1:0] prod;

  // erase_cnt / flag_cnt >= T  rewritten as erase_cnt >= T * flag_cnt
  assign prod = PW'(thresh) * PW'(flag_cnt);
  assign hit  = (flag_cnt != '0) && (CW'(erase_cnt) >= CW'(prod));
endmodule

// File: rtl/erase_flag_tracker.sv
module erase_flag_tracker #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16,
  parameter int THR_W = 12,
  parameter int SH_W  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             erase_vld,
  input  logic [BLK_W-1:0] erase_blk,
  input  logic [THR_W-1:0] thresh,
  input  logic [SH_W-1:0]  grp_shift,
  input  logic [BLK_W-1:0] rd_idx,
  output logic             rd_flag,
  output logic             level_req,
  output logic [CNT_W-1:0] erase_cnt,
  output logic [BLK_W:0]   flag_cnt
);
  localparam int FC_W = BLK_W + 1;
  localparam logic [FC_W-1:0] NUM_GRP = FC_W'(1) << BLK_W;

  logic [SH_W-1:0]  k_eff;
  logic [BLK_W-1:0] set_idx;
  logic [FC_W-1:0]  grp_total;
  logic             tbl_full;
  logic             set_fresh;

  assign k_eff     = SH_W'(ewl_pkg::clamp_shift(int'(grp_shift), BLK_W));
  assign set_idx   = erase_blk >> k_eff;
  assign grp_total = NUM_GRP >> k_eff;
  assign tbl_full  = (flag_cnt == grp_total);

  ewl_flag_table #(.IDX_W(BLK_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (erase_vld),
    .set_idx  (set_idx),
    .clr_all  (tbl_full),
    .rd_idx   (rd_idx),
    .rd_flag  (rd_flag),
    .set_fresh(set_fresh)
  );

  ewl_counters #(.CNT_W(CNT_W), .FC_W(FC_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ev       (erase_vld),
    .fresh    (set_fresh),
    .clr      (tbl_full),
    .erase_cnt(erase_cnt),
    .flag_cnt (flag_cnt)
  );

  ewl_ratio_cmp #(.CNT_W(CNT_W), .THR_W(THR_W), .FC_W(FC_W)) u_cmp (
    .erase_cnt(erase_cnt),
    .flag_cnt (flag_cnt),
    .thresh   (thresh),
    .hit      (level_req)
  );
endmodule

// File: rtl/erase_flag_tracker_chk.sv
module erase_flag_tracker_chk #(
  parameter int BLK_W = 8,
  parameter int CNT_W = 16,
  parameter int SH_W  = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             erase_vld,
  input logic [SH_W-1:0]  grp_shift,
  input logic             level_req,
  input logic [CNT_W-1:0] erase_cnt,
  input logic [BLK_W:0]   flag_cnt
);
  localparam logic [CNT_W-1:0] E_MAX = '1;
  localparam logic [BLK_W:0]   NGRP  = (BLK_W+1)'(1) << BLK_W;

  logic [BLK_W:0] grp_n;
  logic           full_c;
  assign grp_n  = (int'(grp_shift) > BLK_W) ? (BLK_W+1)'(1) : (NGRP >> grp_shift);
  assign full_c = (flag_cnt == grp_n);

  AST_EMPTY_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_cnt == '0) |-> !level_req); // R6
  AST_ERASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_vld && !full_c && erase_cnt != E_MAX) |=> (erase_cnt == $past(erase_cnt) + 1'b1)); // R3
  AST_FLAG_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    !full_c |=> (flag_cnt == $past(flag_cnt) || flag_cnt == $past(flag_cnt) + 1'b1)); // R4
  AST_FULL_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (full_c && !erase_vld) |=> (erase_cnt == '0 && flag_cnt == '0)); // R7
  AST_FULL_RECORD: assert property (@(posedge clk) disable iff (!rst_n)
    (full_c && erase_vld) |=> (erase_cnt == CNT_W'(1) && flag_cnt == (BLK_W+1)'(1))); // R8
  AST_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
    (erase_vld && !full_c && erase_cnt == E_MAX) |=> (erase_cnt == E_MAX)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!erase_vld && !full_c) |=> ($stable(erase_cnt) && $stable(flag_cnt))); // R10
endmodule

bind erase_flag_tracker erase_flag_tracker_chk #(
  .BLK_W(BLK_W), .CNT_W(CNT_W), .SH_W(SH_W)
) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .erase_vld(erase_vld),
  .grp_shift(grp_shift),
  .level_req(level_req),
  .erase_cnt(erase_cnt),
  .flag_cnt (flag_cnt)
);

// File: tb/test_erase_flag_tracker.sv
module test_erase_flag_tracker;
  localparam int BLK_W = 8;
  localparam int CNT_W = 10;
  localparam int THR_W = 12;
  localparam int SH_W  = 4;
  localparam int NBLK  = 1 << BLK_W;
  localparam int EMAX  = (1 << CNT_W) - 1;

  logic             clk;
  logic             rst_n;
  logic             erase_vld;
  logic [BLK_W-1:0] erase_blk;
  logic [THR_W-1:0] thresh;
  logic [SH_W-1:0]  grp_shift;
  logic [BLK_W-1:0] rd_idx;
  logic             rd_flag;
  logic             level_req;
  logic [CNT_W-1:0] erase_cnt;
  logic [BLK_W:0]   flag_cnt;

  erase_flag_tracker #(.BLK_W(BLK_W), .CNT_W(CNT_W), .THR_W(THR_W), .SH_W(SH_W)) i_erase_flag_tracker (
    .clk(clk), .rst_n(rst_n), .erase_vld(erase_vld), .erase_blk(erase_blk),
    .thresh(thresh), .grp_shift(grp_shift), .rd_idx(rd_idx), .rd_flag(rd_flag),
    .level_req(level_req), .erase_cnt(erase_cnt), .flag_cnt(flag_cnt)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int n_checks = 0;
  int n_errors = 0;

  bit m_flag [NBLK];
  int m_ecnt;
  int m_fcnt;

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int k_clamped();
    return (int'(grp_shift) > BLK_W) ? BLK_W : int'(grp_shift);
  endfunction

  function automatic int groups();
    return NBLK >> k_clamped();
  endfunction

  function automatic bit exp_level();
    return (m_fcnt != 0) && (m_ecnt >= int'(thresh) * m_fcnt);
  endfunction

  task automatic model_reset();
    foreach (m_flag[i]) m_flag[i] = 1'b0;
    m_ecnt = 0;
    m_fcnt = 0;
  endtask

  // Called at a negedge; returns at the next negedge after checking.
  task automatic cyc(input bit vld, input int blk, input int ridx);
    string tag_e;
    string tag_f;
    bit    was_full;
    int    gi;
    erase_vld = vld;
    erase_blk = BLK_W'(blk);
    rd_idx    = BLK_W'(ridx);
    was_full  = (m_fcnt == groups());
    tag_e = was_full ? (vld ? "R8" : "R7") : (!vld ? "R10" : ((m_ecnt == EMAX) ? "R9" : "R3"));
    tag_f = was_full ? (vld ? "R8" : "R7") : (!vld ? "R10" : "R4");
    if (int'(grp_shift) > BLK_W) tag_f = {tag_f, "/R11"};
    @(posedge clk);
    if (was_full) model_reset();
    if (vld) begin
      gi = blk >> k_clamped();
      if (m_ecnt < EMAX) m_ecnt++;
      if (!m_flag[gi]) begin
        m_flag[gi] = 1'b1;
        m_fcnt++;
      end
    end
    #5;
    check(tag_e, "erase_cnt", int'(erase_cnt), m_ecnt);
    check(tag_f, "flag_cnt", int'(flag_cnt), m_fcnt);
    check((m_fcnt == 0) ? "R6" : "R5", "level_req", int'(level_req), int'(exp_level()));
    check(was_full ? tag_f : "R2", "rd_flag", int'(rd_flag), int'(m_flag[ridx]));
    @(negedge clk);
  endtask

  task automatic do_reset(input int k, input int t);
    rst_n     = 1'b0;
    erase_vld = 1'b0;
    erase_blk = '0;
    rd_idx    = '0;
    grp_shift = SH_W'(k);
    thresh    = THR_W'(t);
    model_reset();
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 150000);
    n_errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    do_reset(0, 100);

    // R1: reset state
    check("R1", "erase_cnt", int'(erase_cnt), 0);
    check("R1", "flag_cnt", int'(flag_cnt), 0);
    check("R1", "level_req", int'(level_req), 0);
    for (int i = 0; i < 8; i++) begin
      rd_idx = BLK_W'(i * 37);
      #1;
      check("R1", "rd_flag", int'(rd_flag), 0);
    end
    @(negedge clk);

    // R5 threshold equality: k=2, T=100, repeat one group
    do_reset(2, 100);
    for (int i = 0; i < 99; i++) cyc(1'b1, i % 4, 0);
    check("R5", "below threshold", int'(level_req), 0);
    cyc(1'b1, 3, 0);
    check("R5", "at threshold", int'(level_req), 1);
    cyc(1'b1, 4, 1);   // second group: 101 < 200
    check("R5", "two groups", int'(level_req), 0);
    check("R2", "flag of group 1", int'(rd_flag), 1);
    cyc(1'b0, 0, 2);
    check("R10", "idle hold", int'(erase_cnt), 101);

    // R6: T=0 with empty table
    do_reset(0, 0);
    cyc(1'b0, 0, 0);
    check("R6", "empty table T=0", int'(level_req), 0);
    cyc(1'b1, 9, 9);
    check("R6", "one flag T=0", int'(level_req), 1);

    // R9: saturation with repeats in one group
    do_reset(0, 1);
    for (int i = 0; i < EMAX + 20; i++) cyc(1'b1, 5, 5);
    check("R9", "saturated erase_cnt", int'(erase_cnt), EMAX);

    // R11: oversized shift gives one group; each erase fills
    do_reset(12, 3);
    for (int i = 0; i < 40; i++) cyc(($urandom % 2) == 1, $urandom % NBLK, 0);
    cyc(1'b1, 200, 0);
    cyc(1'b1, 17, 0);
    check("R8", "erase on full (R11)", int'(erase_cnt), 1);
    cyc(1'b0, 0, 0);
    check("R7", "clear when full (R11)", int'(flag_cnt), 0);

    // Random phases: 4 groups, 16 groups, 256 groups
    for (int ph = 0; ph < 3; ph++) begin
      int kk;
      kk = (ph == 0) ? 6 : ((ph == 1) ? 4 : 0);
      do_reset(kk, 1 + ($urandom % 5));
      for (int i = 0; i < 1500; i++) begin
        int g;
        g = groups();
        cyc(($urandom % 4) != 0, $urandom % NBLK, $urandom % g);
      end
    end

    // R7/R8 directed with 4 groups
    do_reset(6, 2);
    cyc(1'b1, 0, 0); cyc(1'b1, 64, 0); cyc(1'b1, 128, 0); cyc(1'b1, 192, 3);
    check("R7", "table full count", int'(flag_cnt), 4);
    cyc(1'b1, 130, 2);
    check("R8", "post-clear erase_cnt", int'(erase_cnt), 1);
    check("R8", "post-clear flag_cnt", int'(flag_cnt), 1);
    check("R8", "recorded flag", int'(rd_flag), 1);

    $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end
endmodule